// File: doc/BRIEF.md
# Insert/Delete Shifting Byte Store

This block is a 1024-byte memory reached through one byte-wide host port and a single 10-bit address pointer. A command write selects one of two access modes, loads the pointer, or steps it back by one. Data reads and writes then act on the byte under the pointer.

In sequential mode a read or write touches the byte at the pointer and then advances the pointer. In shifting mode a write opens a gap at the pointer by moving every later meaningful byte one place toward higher addresses. A read takes the byte at the pointer out and closes the gap by moving later bytes one place toward lower addresses. In shifting mode the pointer stays where it is. The block keeps a fill count that marks the end of meaningful data. Shifts run one byte per clock, and the busy output stays high until a shift ends.

Top module: `shift_byte_store`

## Requirements
- R1: A synchronous active-low reset clears busy, stat and full. It selects sequential mode and sets both the pointer and the fill count to zero. Stored bytes are left as they were.
- R2: In sequential mode a data write stores din at the pointer. A data read returns the byte at the pointer on dout. After either access the pointer advances by one. A write at or past the fill count raises the fill count to pointer+1.
- R3: In shifting mode, when pointer ≤ fill and the store is not full, a data write puts din at the pointer. Bytes from the old pointer up to the old end each move one address higher, and the fill count grows by one.
- R4: In shifting mode, when pointer < fill, a data read returns the byte at the pointer. Later bytes each move one address lower and the fill count drops by one. The pointer is unchanged, so a second read returns the byte that followed.
- R5: A shifting-mode read with pointer ≥ fill returns 0x00, sets stat, and changes no stored byte and no count.
- R6: A shifting-mode write with pointer > fill, or while full, is ignored and sets stat.
- R7: busy stays high for fill−pointer+1 cycles after an insert and for fill−pointer cycles after a removal. The pointer is held while busy is high, and host accesses made while busy is high are ignored.
- R8: Command 0x03 lowers the pointer by one and clears stat. When the pointer is already 0, it leaves the pointer at 0 and sets stat.
- R9: full is high exactly when the fill count equals 1024. While full is high the fill count never grows.
- R10: A host write with cmd=1 is a command. 0x01 selects sequential mode and 0x02 selects shifting mode. 0b100vvvvv loads pointer bits 4:0 and 0b110vvvvv loads pointer bits 9:5. Every accepted access or command other than those in R5, R6 and R8 clears stat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | Host access strobe, one cycle per access |
| wr | input | 1 | Host write |
| rd | input | 1 | Host read |
| cmd | input | 1 | 1 = command byte, 0 = data byte |
| din | input | 8 | Write data or command byte |
| dout | output | 8 | Read data, registered |
| busy | output | 1 | High while a shift is in progress |
| stat | output | 1 | Exception flag from the last accepted operation |
| full | output | 1 | No room for one more byte |

## Verification
The hardest condition to reach from the ports is a full store, because no single command fills it. The stimulus loads the pointer to the top address and makes one sequential write there. By R2 that write raises the fill count to 1024, which lets the bench test the full flag and a refused insert without writing a thousand bytes. The shift counts are checked by counting busy cycles for an insert and a removal in the middle of the data and for an append at the end. Stored contents are confirmed by reading them back in sequential mode.

// File: rtl/sbs_pkg.sv
// Shared types for the shifting byte store.
// Assumes: opcode values below are the host-visible command encoding.
package sbs_pkg;
    typedef enum logic [2:0] {
        OP_NONE, OP_MODE_SEQ, OP_MODE_SHIFT, OP_DEC,
        OP_LOAD_LO, OP_LOAD_HI, OP_WRITE, OP_READ
    } op_t;

    typedef enum logic [1:0] { ST_IDLE, ST_INSERT, ST_REMOVE } state_t;

    localparam logic [7:0] CODE_SEQ   = 8'h01;
    localparam logic [7:0] CODE_SHIFT = 8'h02;
    localparam logic [7:0] CODE_DEC   = 8'h03;
endpackage

// File: rtl/sbs_decode.sv
// Turns a host strobe into one operation code.
// Assumes: accesses arriving while busy are dropped here.
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic              cmd,
    input  logic              busy,
    input  logic [DATA_W-1:0] din,
    output op_t               op
);
    // Classify the access; illegal read+write is no operation.
    always_comb begin
        op = OP_NONE;
        if (sel && !busy && (wr ^ rd)) begin
            if (!cmd) begin
                op = wr ? OP_WRITE : OP_READ;
            end else if (wr) begin
                if (din[DATA_W-1:DATA_W-3] == 3'b100)      op = OP_LOAD_LO;
                else if (din[DATA_W-1:DATA_W-3] == 3'b110) op = OP_LOAD_HI;
                else if (din == CODE_SEQ)                  op = OP_MODE_SEQ;
                else if (din == CODE_SHIFT)                op = OP_MODE_SHIFT;
                else if (din == CODE_DEC)                  op = OP_DEC;
            end
        end
    end
endmodule

// File: rtl/sbs_array.sv
// Byte storage with one write port and one combinational read port.
// Assumes: no reset on contents; logical emptiness is kept by the controller.
module sbs_array #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Single write per clock.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sbs_ctrl.sv
// Pointer, fill count, mode and the shift sequencer.
// Assumes: ADDR_W split in two load halves each fitting in 5 command bits.
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    localparam int FILL_W = ADDR_W + 1,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int LO_W   = (ADDR_W + 1) / 2,
    localparam int HI_W   = ADDR_W - LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_t               op,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] dout,
    output logic              busy,
    output logic              stat,
    output logic              full,
    output logic              shift_mode,
    output logic [ADDR_W-1:0] ptr,
    output logic [FILL_W-1:0] fill
);
    state_t            state;
    logic [FILL_W-1:0] idx;
    logic [DATA_W-1:0] hold;
    logic [FILL_W-1:0] ptr_x;

    assign ptr_x = {1'b0, ptr};
    assign full  = (fill == FILL_W'(DEPTH));
    assign busy  = (state != ST_IDLE);

    // Steer the single read and write port for host access or shift step.
    always_comb begin
        raddr = ptr;
        we    = 1'b0;
        waddr = ptr;
        wdata = din;
        unique case (state)
            ST_INSERT: begin
                we = 1'b1;
                if (idx == ptr_x) begin
                    wdata = hold;
                end else begin
                    raddr = ADDR_W'(idx - FILL_W'(1));
                    waddr = idx[ADDR_W-1:0];
                    wdata = rdata;
                end
            end
            ST_REMOVE: begin
                if (idx + FILL_W'(1) < fill) begin
                    raddr = ADDR_W'(idx + FILL_W'(1));
                    we    = 1'b1;
                    waddr = idx[ADDR_W-1:0];
                    wdata = rdata;
                end
            end
            default: begin
                we = (op == OP_WRITE) && !shift_mode;
            end
        endcase
    end

    // Sequence host operations and shift steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            shift_mode <= 1'b0;
            ptr        <= '0;
            fill       <= '0;
            idx        <= '0;
            hold       <= '0;
            dout       <= '0;
            stat       <= 1'b0;
        end else begin
            unique case (state)
                ST_INSERT: begin
                    if (idx == ptr_x) begin
                        fill  <= fill + FILL_W'(1);
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx - FILL_W'(1);
                    end
                end
                ST_REMOVE: begin
                    if (idx + FILL_W'(1) >= fill) begin
                        fill  <= fill - FILL_W'(1);
                        state <= ST_IDLE;
                    end else begin
                        idx <= idx + FILL_W'(1);
                    end
                end
                default: begin
                    if (op != OP_NONE) stat <= 1'b0;
                    unique case (op)
                        OP_MODE_SEQ:   shift_mode <= 1'b0;
                        OP_MODE_SHIFT: shift_mode <= 1'b1;
                        OP_DEC: begin
                            if (ptr == '0) stat <= 1'b1;
                            else           ptr  <= ptr - ADDR_W'(1);
                        end
                        OP_LOAD_LO: ptr[LO_W-1:0]      <= din[LO_W-1:0];
                        OP_LOAD_HI: ptr[ADDR_W-1:LO_W] <= din[HI_W-1:0];
                        OP_WRITE: begin
                            if (!shift_mode) begin
                                ptr <= ptr + ADDR_W'(1);
                                if (ptr_x >= fill) fill <= ptr_x + FILL_W'(1);
                            end else if (full || ptr_x > fill) begin
                                stat <= 1'b1;
                            end else begin
                                hold  <= din;
                                idx   <= fill;
                                state <= ST_INSERT;
                            end
                        end
                        OP_READ: begin
                            if (!shift_mode) begin
                                dout <= rdata;
                                ptr  <= ptr + ADDR_W'(1);
                            end else if (ptr_x >= fill) begin
                                dout <= '0;
                                stat <= 1'b1;
                            end else begin
                                dout  <= rdata;
                                idx   <= ptr_x;
                                state <= ST_REMOVE;
                            end
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/shift_byte_store.sv
// Top: host-port byte memory with sequential and shifting access modes.
// Assumes: one access per sel pulse; hosts wait for busy low.
module shift_byte_store
    import sbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    localparam int FILL_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic              cmd,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy,
    output logic              stat,
    output logic              full
);
    op_t               op;
    logic [ADDR_W-1:0] raddr, waddr, ptr_w;
    logic [DATA_W-1:0] rdata, wdata;
    logic              we, shift_mode_w;
    logic [FILL_W-1:0] fill_w;

    sbs_decode #(.DATA_W(DATA_W)) u_decode (
        .sel(sel), .wr(wr), .rd(rd), .cmd(cmd), .busy(busy), .din(din), .op(op)
    );

    sbs_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    sbs_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .op(op), .din(din), .rdata(rdata),
        .raddr(raddr), .we(we), .waddr(waddr), .wdata(wdata),
        .dout(dout), .busy(busy), .stat(stat), .full(full),
        .shift_mode(shift_mode_w), .ptr(ptr_w), .fill(fill_w)
    );
endmodule

// File: rtl/sbs_checker.sv
// Temporal checks on the shifting byte store, bound to the top.
// Assumes: default parameters for the top instance it watches.
module sbs_checker #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    localparam int FILL_W = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic              rd,
    input logic              cmd,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              busy,
    input logic              stat,
    input logic              full,
    input logic              shift_mode,
    input logic [ADDR_W-1:0] ptr,
    input logic [FILL_W-1:0] fill
);
    // Reset lands the block idle and empty.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !stat && !full && fill == '0 && ptr == '0));

    // Pointer frozen while a shift runs.
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

    // Fill count moves by at most one per clock in shifting mode.
    assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode && $past(shift_mode)) |->
            (fill == $past(fill) || fill == $past(fill) + FILL_W'(1)
             || fill + FILL_W'(1) == $past(fill)));

    // Full store never grows.
    assert_full_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (fill <= $past(fill)));

    // Decrement at zero floors and flags.
    assert_dec_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !rd && cmd && din == 8'h03 && !busy && ptr == '0)
            |=> (ptr == '0 && stat));

    // Removal from empty region returns zero without a shift.
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && !wr && !cmd && !busy && shift_mode && {1'b0, ptr} >= fill)
            |=> (dout == '0 && stat && !busy));
endmodule

bind shift_byte_store sbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .cmd(cmd),
    .din(din), .dout(dout), .busy(busy), .stat(stat), .full(full),
    .shift_mode(shift_mode_w), .ptr(ptr_w), .fill(fill_w)
);

// File: tb/tb_shift_byte_store.sv
`timescale 1ns/1ps
// Directed bench for the shifting byte store.
module tb_shift_byte_store;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, cmd = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       busy, stat, full;
    int         errors = 0;
    int         checks = 0;
    int         cycles = 0;

    shift_byte_store dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .cmd(cmd),
        .din(din), .dout(dout), .busy(busy), .stat(stat), .full(full)
    );

    always #2 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // One host access; returns busy-cycle count.
    task automatic access(input bit is_wr, input bit is_cmd, input logic [7:0] b,
                          output int nbusy);
        @(negedge clk);
        sel = 1'b1; wr = is_wr; rd = !is_wr; cmd = is_cmd; din = b;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; rd = 1'b0; cmd = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy = nbusy + 1;
            @(negedge clk);
        end
    endtask

    task automatic command(input logic [7:0] b);
        int n;
        access(1'b1, 1'b1, b, n);
    endtask

    task automatic put(input logic [7:0] b, output int n);
        access(1'b1, 1'b0, b, n);
    endtask

    task automatic get(output logic [7:0] b, output int n);
        access(1'b0, 1'b0, 8'h00, n);
        b = dout;
    endtask

    task automatic set_ptr(input int v);
        command(8'h80 | 8'(v & 31));
        command(8'hC0 | 8'((v >> 5) & 31));
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check(!busy && !stat && !full, "R1 idle after reset", {busy, stat, full}, 0);
    endtask

    task automatic t_sequential();
        int n; logic [7:0] b;
        set_ptr(0);
        put(8'h11, n); put(8'h22, n); put(8'h33, n);
        set_ptr(0);
        get(b, n); check(b == 8'h11, "R2 seq read 0", b, 8'h11);
        get(b, n); check(b == 8'h22, "R2 seq read 1", b, 8'h22);
        get(b, n); check(b == 8'h33, "R2 seq read 2", b, 8'h33);
    endtask

    task automatic t_insert();
        int n; logic [7:0] b;
        command(8'h02); set_ptr(1);
        put(8'hAA, n);
        check(n == 3, "R7 insert busy cycles", n, 3);
        check(!stat, "R3 insert stat", stat, 0);
        command(8'h01); set_ptr(0);
        get(b, n); check(b == 8'h11, "R3 after insert 0", b, 8'h11);
        get(b, n); check(b == 8'hAA, "R3 after insert 1", b, 8'hAA);
        get(b, n); check(b == 8'h22, "R3 after insert 2", b, 8'h22);
        get(b, n); check(b == 8'h33, "R3 after insert 3", b, 8'h33);
    endtask

    task automatic t_remove();
        int n; logic [7:0] b;
        command(8'h02); set_ptr(1);
        get(b, n);
        check(b == 8'hAA, "R4 popped byte", b, 8'hAA);
        check(n == 3, "R7 remove busy cycles", n, 3);
        get(b, n);
        check(b == 8'h22, "R4 pointer fixed, next byte", b, 8'h22);
        command(8'h01); set_ptr(0);
        get(b, n); check(b == 8'h11, "R4 after remove 0", b, 8'h11);
        get(b, n); check(b == 8'h33, "R4 after remove 1", b, 8'h33);
    endtask

    task automatic t_empty_and_append();
        int n; logic [7:0] b;
        command(8'h02); set_ptr(2);
        get(b, n);
        check(b == 8'h00 && stat && n == 0, "R5 read past end", {b, stat}, 9'h001);
        put(8'h44, n);
        check(n == 1, "R7 append busy cycles", n, 1);
        check(!stat, "R10 stat cleared on good access", stat, 0);
        get(b, n);
        check(b == 8'h44, "R3 appended byte", b, 8'h44);
        set_ptr(5);
        put(8'h99, n);
        check(stat && n == 0, "R6 write beyond end flagged", stat, 1);
        set_ptr(2);
        get(b, n);
        check(b == 8'h00 && stat, "R6 fill unchanged by gap write", {b, stat}, 9'h001);
    endtask

    task automatic t_decrement();
        int n; logic [7:0] b;
        command(8'h01); set_ptr(0);
        command(8'h03);
        check(stat, "R8 dec at zero flags", stat, 1);
        get(b, n); check(b == 8'h11, "R8 pointer stayed at 0", b, 8'h11);
        set_ptr(2); command(8'h03);
        check(!stat, "R8 dec clears stat", stat, 0);
        get(b, n); check(b == 8'h33, "R8 dec moved to 1", b, 8'h33);
    endtask

    task automatic t_full();
        int n; logic [7:0] b;
        command(8'h01); set_ptr(1023);
        put(8'h5A, n);
        check(full, "R9 full after top write", full, 1);
        command(8'h02); set_ptr(1023);
        put(8'h77, n);
        check(stat && n == 0 && full, "R6 insert refused when full", stat, 1);
        command(8'h01); set_ptr(1023);
        get(b, n); check(b == 8'h5A, "R6 top byte kept", b, 8'h5A);
    endtask

    task automatic t_reset_empty();
        int n; logic [7:0] b;
        do_reset();
        check(!full && !stat && !busy, "R1 full cleared by reset", full, 0);
        set_ptr(1);
        get(b, n); check(b == 8'h33, "R1 contents kept, seq mode", b, 8'h33);
        command(8'h02); set_ptr(0);
        get(b, n); check(b == 8'h00 && stat, "R1 fill zero after reset", {b, stat}, 9'h001);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_sequential();
        t_insert();
        t_remove();
        t_empty_and_append();
        t_decrement();
        t_full();
        t_reset_empty();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule